// File: doc/BRIEF.md
# Flash Readback Verify Sequencer

This block runs on the host side of a debug link. It checks the flash contents of a target processor one word at a time. After an accepted start it sends one setup instruction word. That word points a target register at the base of the fast-data window. Then, for each word address in the requested range, it generates four instruction words. Two of them load the address into a target register, one at a time for the upper and lower halves. The third loads the flash word from that address. The fourth stores the word into the fast-data window. Every instruction word is offered on a valid/ready port to an external transfer engine.

Once the four words of a location have been accepted, the block waits for the transfer engine to return the fast-data word. While it waits, it asks the local buffer for the expected word at the same address. It compares the two words in the cycle the returned word is marked valid. The first mismatch stops the run and records the address that failed. If every location matches, the run ends with pass.

Top module: `flash_verify_seq`

## Requirements
- R1: While reset is asserted and after it is released, insn_valid_o, exp_req_o, done_o, pass_o and fail_o are 0 and fail_addr_o is 0.
- R2: A start accepted in idle makes insn_o = 0x3C13FF20 with insn_valid_o = 1 in the next cycle. This setup word comes before any per-location word.
- R3: For each location at address A, the block sends these words in order: {0x3C08, A[31:16]}, then {0x3508, A[15:0]}, then 0x8D090000, then 0xAE690000.
- R4: An offered word keeps insn_valid_o high and insn_o unchanged until a cycle in which insn_ready_i is 1. The next word, if any, appears in the following cycle.
- R5: After the fourth word of a location is accepted, exp_req_o is 1 and exp_addr_o equals the location address. This lasts until rdata_valid_i is 1. At that edge rdata_i is compared with exp_data_i. rdata_valid_i has no effect at any other time.
- R6: The first location is base_addr_i as sampled at the accepted start. Each following location is 4 higher. Exactly word_cnt_i locations are read.
- R7: When the last location matches, done_o and pass_o go to 1 in the next cycle and stay there. fail_o stays 0, and no further word is offered.
- R8: On a mismatch, done_o and fail_o go to 1 in the next cycle, and fail_addr_o holds the address of the mismatching location. No further word is offered, and no later location is read.
- R9: start_i is ignored while a run is in progress. This means while a word is offered or while the block waits for read data.
- R10: A start with word_cnt_i = 0 sends only the setup word. It then ends with done_o = 1 and pass_o = 1.
- R11: An accepted start clears done_o, pass_o, fail_o and fail_addr_o in the next cycle. The setup word is sent again on every new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a verify run, taken only when idle |
| base_addr_i | input | 32 | First word address of the range |
| word_cnt_i | input | CNT_W | Number of words to verify |
| insn_o | output | 32 | Instruction word for the target |
| insn_valid_o | output | 1 | insn_o is offered |
| insn_ready_i | input | 1 | Transfer engine takes insn_o |
| rdata_i | input | 32 | Word read back from the fast-data window |
| rdata_valid_i | input | 1 | rdata_i is valid |
| exp_req_o | output | 1 | Request for the expected word |
| exp_addr_o | output | 32 | Address of the expected word |
| exp_data_i | input | 32 | Expected word from the local buffer, same cycle |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | All locations matched |
| fail_o | output | 1 | A mismatch stopped the run |
| fail_addr_o | output | 32 | Address of the mismatching location |

## Verification
A wrong state register shows up at once on the instruction port. In the cycle after a bad transition, the bench sees a skipped, repeated or out-of-order word, or a valid or request strobe at the wrong time. A wrong address or count register takes longer to show. It appears in the low or high half of the next location's first two words, or on the expected-data address. It can also appear as a run that ends one location early or late, which is only seen at the final done. Each of these is compared against a behavioural model on every clock. The range that crosses a 64 KiB boundary is there to expose a bad upper half. Mismatches placed in the middle and at the last location expose late or missing halts.

// File: rtl/fvs_pkg.sv
package fvs_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HI,
    ST_LO,
    ST_LOAD,
    ST_STORE,
    ST_RD
  } fvs_state_e;

  localparam logic [WORD_W-1:0] PRE_WORD   = 32'h3C13_FF20;
  localparam logic [15:0]       HI_OP      = 16'h3C08;
  localparam logic [15:0]       LO_OP      = 16'h3508;
  localparam logic [WORD_W-1:0] LOAD_WORD  = 32'h8D09_0000;
  localparam logic [WORD_W-1:0] STORE_WORD = 32'hAE69_0000;
endpackage

// File: rtl/fvs_word_gen.sv
module fvs_word_gen
  import fvs_pkg::*;
(
  input  fvs_state_e        state_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int unsigned HALF_W = WORD_W / 2;

  always_comb begin
    word_o  = '0;
    valid_o = 1'b1;
    unique case (state_i)
      ST_PRE:   word_o = PRE_WORD;
      ST_HI:    word_o = {HI_OP, addr_i[WORD_W-1:HALF_W]};
      ST_LO:    word_o = {LO_OP, addr_i[HALF_W-1:0]};
      ST_LOAD:  word_o = LOAD_WORD;
      ST_STORE: word_o = STORE_WORD;
      default:  valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fvs_walker.sv
module fvs_walker
  import fvs_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] addr_o,
  output logic              last_o,
  output logic              empty_o
);
  localparam logic [WORD_W-1:0] STRIDE = WORD_W'(4);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      left_q <= '0;
    end else if (load_i) begin
      addr_o <= base_i;
      left_q <= cnt_i;
    end else if (step_i) begin
      addr_o <= addr_o + STRIDE;
      left_q <= left_q - 1'b1;
    end
  end

  assign last_o  = (left_q == CNT_W'(1));
  assign empty_o = (left_q == '0);

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> addr_o == $past(addr_o) + STRIDE);  // R6
  AST_LOAD_STEP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && step_i));  // R6
endmodule

// File: rtl/fvs_result.sv
module fvs_result
  import fvs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pass_set_i,
  input  logic              fail_set_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [WORD_W-1:0] fail_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
    end else if (clr_i) begin
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
    end else if (fail_set_i) begin
      fail_o      <= 1'b1;
      fail_addr_o <= addr_i;
    end else if (pass_set_i) begin
      pass_o <= 1'b1;
    end
  end

  assign done_o = pass_o | fail_o;

  AST_PASS_FAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));  // R7
  AST_SET_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_set_i && fail_set_i));  // R8
endmodule

// File: rtl/flash_verify_seq.sv
module flash_verify_seq
  import fvs_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       base_addr_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  output logic [31:0]       insn_o,
  output logic              insn_valid_o,
  input  logic              insn_ready_i,
  input  logic [31:0]       rdata_i,
  input  logic              rdata_valid_i,
  output logic              exp_req_o,
  output logic [31:0]       exp_addr_o,
  input  logic [31:0]       exp_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [31:0]       fail_addr_o
);
  fvs_state_e state_q, state_d;
  logic [WORD_W-1:0] addr;
  logic start_ok, hs, got_rd, mismatch, last_loc, no_loc;
  logic step, pass_set, fail_set;

  assign start_ok = start_i && (state_q == ST_IDLE);
  assign hs       = insn_valid_o && insn_ready_i;
  assign got_rd   = (state_q == ST_RD) && rdata_valid_i;
  assign mismatch = (rdata_i != exp_data_i);

  always_comb begin
    state_d  = state_q;
    step     = 1'b0;
    pass_set = 1'b0;
    fail_set = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (start_ok) state_d = ST_PRE;
      ST_PRE:   if (hs) begin
                  state_d  = no_loc ? ST_IDLE : ST_HI;
                  pass_set = no_loc;
                end
      ST_HI:    if (hs) state_d = ST_LO;
      ST_LO:    if (hs) state_d = ST_LOAD;
      ST_LOAD:  if (hs) state_d = ST_STORE;
      ST_STORE: if (hs) state_d = ST_RD;
      ST_RD:    if (got_rd) begin
                  if (mismatch) begin
                    state_d  = ST_IDLE;
                    fail_set = 1'b1;
                  end else if (last_loc) begin
                    state_d  = ST_IDLE;
                    pass_set = 1'b1;
                  end else begin
                    state_d = ST_HI;
                    step    = 1'b1;
                  end
                end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  fvs_walker #(.CNT_W(CNT_W)) i_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ok),
    .base_i  (base_addr_i),
    .cnt_i   (word_cnt_i),
    .step_i  (step),
    .addr_o  (addr),
    .last_o  (last_loc),
    .empty_o (no_loc)
  );

  fvs_word_gen i_word_gen (
    .state_i (state_q),
    .addr_i  (addr),
    .word_o  (insn_o),
    .valid_o (insn_valid_o)
  );

  fvs_result i_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_ok),
    .pass_set_i  (pass_set),
    .fail_set_i  (fail_set),
    .addr_i      (addr),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o)
  );

  assign exp_req_o  = (state_q == ST_RD);
  assign exp_addr_o = addr;

  AST_INSN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o && !insn_ready_i |=> insn_valid_o && $stable(insn_o));  // R4
  AST_PRE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !insn_valid_o && !exp_req_o |=> insn_valid_o && insn_o == PRE_WORD);  // R2
  AST_FAIL_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o && !insn_valid_o && !exp_req_o);  // R8
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_req_o && start_i && !rdata_valid_i |=> exp_req_o);  // R9
  AST_NO_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o || exp_req_o |-> !done_o);  // R11
  AST_REQ_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exp_req_o && insn_valid_o));  // R5
endmodule

// File: tb/test_flash_verify_seq.sv
`timescale 1ns/1ps
module test_flash_verify_seq;
  localparam int CW = 16;
  localparam logic [31:0] PRE = 32'h3C13_FF20;
  localparam logic [31:0] NONE = 32'h0000_0001;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, insn_ready_i = 1'b0, rdata_valid_i = 1'b0;
  logic [31:0] base_addr_i = '0, rdata_i = '0;
  logic [CW-1:0] word_cnt_i = '0;
  logic [31:0] insn_o, exp_addr_o, exp_data_i, fail_addr_o;
  logic insn_valid_o, exp_req_o, done_o, pass_o, fail_o;

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_en = 0;
  logic [31:0] bad_addr = NONE;

  // behavioural reference state
  logic [31:0] m_q[$];
  bit m_pre, m_wait, m_done, m_pass, m_fail;
  logic [31:0] m_addr, m_faddr;
  int m_left;

  always #2 clk = ~clk;

  function automatic logic [31:0] buf_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  assign exp_data_i = buf_word(exp_addr_o);

  flash_verify_seq #(.CNT_W(CW)) i_flash_verify_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .base_addr_i(base_addr_i),
    .word_cnt_i(word_cnt_i), .insn_o(insn_o), .insn_valid_o(insn_valid_o),
    .insn_ready_i(insn_ready_i), .rdata_i(rdata_i), .rdata_valid_i(rdata_valid_i),
    .exp_req_o(exp_req_o), .exp_addr_o(exp_addr_o), .exp_data_i(exp_data_i),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_busy();
    return (m_q.size() != 0) || m_wait;
  endfunction

  function automatic void push_loc(logic [31:0] a);
    m_q.push_back({16'h3C08, a[31:16]});
    m_q.push_back({16'h3508, a[15:0]});
    m_q.push_back(32'h8D09_0000);
    m_q.push_back(32'hAE69_0000);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete(); m_pre = 0; m_wait = 0;
      m_done = 0; m_pass = 0; m_fail = 0; m_addr = '0; m_faddr = '0; m_left = 0;
    end else if (!m_busy()) begin
      if (start_i) begin
        m_done = 0; m_pass = 0; m_fail = 0; m_faddr = '0;
        m_addr = base_addr_i; m_left = int'(word_cnt_i);
        m_pre = 1; m_q.push_back(PRE);
      end
    end else if (m_q.size() != 0) begin
      if (insn_ready_i) begin
        void'(m_q.pop_front());
        if (m_pre) begin
          m_pre = 0;
          if (m_left == 0) begin m_done = 1; m_pass = 1; end
          else push_loc(m_addr);
        end else if (m_q.size() == 0) m_wait = 1;
      end
    end else if (rdata_valid_i) begin
      m_wait = 0;
      if (m_addr == bad_addr) begin
        m_done = 1; m_fail = 1; m_faddr = m_addr;
      end else if (m_left == 1) begin
        m_done = 1; m_pass = 1; m_left = 0;
      end else begin
        m_addr = m_addr + 4; m_left--; push_loc(m_addr);
      end
    end
  end

  // per-cycle compare, then drive random handshake inputs
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(insn_valid_o === (m_q.size() != 0), "R4 insn_valid_o", 32'(insn_valid_o), 32'(m_q.size() != 0));
      if (m_q.size() != 0)
        chk(insn_o === m_q[0], m_pre ? "R2 insn_o setup" : "R3 insn_o", insn_o, m_q[0]);
      chk(exp_req_o === m_wait, "R5 exp_req_o", 32'(exp_req_o), 32'(m_wait));
      if (m_wait) chk(exp_addr_o === m_addr, "R6 exp_addr_o", exp_addr_o, m_addr);
      chk(done_o === m_done, "R7 done_o", 32'(done_o), 32'(m_done));
      chk(pass_o === m_pass, "R7 pass_o", 32'(pass_o), 32'(m_pass));
      chk(fail_o === m_fail, "R8 fail_o", 32'(fail_o), 32'(m_fail));
      chk(fail_addr_o === m_faddr, "R8 fail_addr_o", fail_addr_o, m_faddr);
    end
    insn_ready_i  = ($urandom % 4) != 0;
    rdata_valid_i = ($urandom % 3) == 0;
    rdata_i = (m_addr == bad_addr) ? ~buf_word(m_addr) : buf_word(m_addr);
    if (!m_wait && rdata_valid_i) rdata_i = $urandom;  // stray strobe, R5
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R7 watchdog: done_o=%0d expected 1", done_o);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [31:0] base, input int cnt, input logic [31:0] bad, input bit poke);
    @(negedge clk);
    bad_addr = bad; base_addr_i = base; word_cnt_i = CW'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(insn_valid_o && insn_o == PRE, "R11 setup resent", insn_o, PRE);
    chk(!done_o, "R11 done cleared", 32'(done_o), 32'h0);
    if (poke) begin
      repeat (3) @(negedge clk);
      base_addr_i = 32'hDEAD_0000; word_cnt_i = CW'(7); start_i = 1'b1;  // R9
      @(negedge clk);
      start_i = 1'b0;
    end
    while (m_busy()) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    cmp_en = 0;
    repeat (3) @(negedge clk);
    chk(!insn_valid_o && !exp_req_o && !done_o && !pass_o && !fail_o,
        "R1 reset outputs", {insn_valid_o, exp_req_o, done_o, pass_o, fail_o}, 32'h0);
    chk(fail_addr_o == 0, "R1 fail_addr_o", fail_addr_o, 32'h0);
    rst_ni = 1'b1;
    cmp_en = 1;
    repeat (2) @(negedge clk);
    chk(!insn_valid_o && !done_o, "R1 idle after reset", {insn_valid_o, done_o}, 32'h0);

    run(32'h1D00_0000, 5, NONE, 1'b1);
    chk(done_o && pass_o && !fail_o, "R7 R9 pass after poke", {done_o, pass_o, fail_o}, 32'h6);

    run(32'h1D00_FFF8, 4, 32'h1D01_0000, 1'b0);
    chk(fail_o && fail_addr_o == 32'h1D01_0000, "R8 fail addr", fail_addr_o, 32'h1D01_0000);
    repeat (10) begin
      @(negedge clk);
      chk(!insn_valid_o && fail_o, "R8 halted", {insn_valid_o, fail_o}, 32'h1);
    end

    run(32'h1FC0_0000, 0, NONE, 1'b0);
    chk(done_o && pass_o, "R10 zero count", {done_o, pass_o}, 32'h3);

    run(32'h0000_0100, 3, 32'h0000_0108, 1'b0);
    chk(fail_o && fail_addr_o == 32'h108, "R8 last location", fail_addr_o, 32'h108);

    run(32'h0000_0100, 3, NONE, 1'b0);
    chk(pass_o && !fail_o && fail_addr_o == 0, "R11 R6 pass after fail", {pass_o, fail_o}, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule